// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller for an external dual-slope integrating converter. It drives the front end through a two-bit phase-select code and watches the front end's zero-crossing comparator. A one-cycle start request sends the front end through four phases, each in turn. It first nulls the offsets. It then integrates the input for a programmed number of clocks, ramps the integrator back down with the reference while it counts clocks, and finally clears the residual charge on the integrator. After this it waits again in the offset-nulling phase.

The comparator arrives asynchronously. It passes through a two-flop synchroniser, and edges are detected on the synchronised copy. The input polarity is taken from the comparator in the last integrate clock. The magnitude is the deintegrate count at the synchronised falling edge, less a fixed latency correction. If the ramp does not cross zero within full scale, the result is flagged as overrange. The integrator-clearing phase ends one clock after the comparator is seen high, or after a timeout.

The state machine has five states. IDLE and AZ_RUN both drive the auto-zero code. INTEG drives the integrate code, DEINT the deintegrate code and IZERO the integrator-zero code. The transitions are:
- go: IDLE to AZ_RUN on start.
- az_done: AZ_RUN to INTEG when the auto-zero count expires.
- int_done: INTEG to DEINT when the integrate count expires, taking the sign.
- zero_cross: DEINT to IZERO on a synchronised falling edge.
- full_scale: DEINT to IZERO on reaching the full-scale count, setting overrange.
- cleared: IZERO to IDLE when the comparator is seen high.
- iz_timeout: IZERO to IDLE when the timeout count expires.

Top module: `dslope_seq`

## Requirements
- R1: The phase-select code is 2'b00 for integrator zero, 2'b01 for auto-zero, 2'b10 for integrate and 2'b11 for deintegrate. After reset the code is 2'b01, and busy, done and overrange are 0.
- R2: A conversion always steps through the codes in the order 01, 10, 11, 00 and then back to 01.
- R3: With no conversion running, the code stays at 01 for as long as start stays low. A start pulse during a conversion is ignored and changes no phase length.
- R4: The auto-zero phase lasts `az_len` clocks after the clock that accepts start. When `az_len` is 0 it lasts `int_len` clocks instead. Comparator activity during auto-zero has no effect.
- R5: The integrate phase (code 10) lasts exactly `int_len` clocks.
- R6: `result_pos` takes the synchronised comparator value in the last integrate clock (1 means positive). Earlier toggles in integrate have no effect, and the bit holds until the next conversion takes a new sign.
- R7: Let D be the number of clocks that the comparator input stays high after the first deintegrate clock is observed. With `LAT_COMP` = 2, the deintegrate phase lasts D+3 clocks and `result_mag` equals D, provided D+2 ≤ 2·`int_len`−1.
- R8: If no synchronised falling edge arrives, deintegrate lasts 2·`int_len` clocks. In that case `overrange` is set and `result_mag` saturates to 2·`int_len`. A conversion that ends on a normal edge clears `overrange`.
- R9: Integrator zero ends on the clock after the synchronised comparator reads high, and the code then goes to 01. A comparator raised Z clocks into the phase ends it after Z+3 clocks. A comparator that is already high ends it after 1 clock.
- R10: Integrator zero never lasts more than `int_len` clocks.
- R11: `done` is a one-clock pulse in the first clock back in auto-zero, with busy already low. The results are valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled while idle |
| cmp_in | input | 1 | Asynchronous zero-crossing comparator input |
| int_len | input | CNT_W | Integrate length in clocks (at least 4) |
| az_len | input | CNT_W | Auto-zero length in clocks (0 means use `int_len`) |
| phase_sel | output | 2 | Phase code to the front end (MSB is A, LSB is B) |
| busy | output | 1 | A conversion is in progress |
| done | output | 1 | One-clock pulse at the end of a conversion |
| result_pos | output | 1 | Sign of the last conversion (1 means positive) |
| result_mag | output | CNT_W+1 | Magnitude of the last conversion |
| overrange | output | 1 | The last conversion reached full scale |

## Verification
Most internal faults show up as a phase code that holds for the wrong number of clocks. A wrong state or timer value shows up that way within the conversion it occurs in, so the bench counts the clocks of every phase against the programmed lengths. A wrongly captured sign, count or overrange flag shows up on the result ports during the done pulse of the same conversion. A fault in the synchroniser or edge detector moves the deintegrate and integrator-zero lengths by whole clocks, and this is visible one phase later.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AZ_RUN,
        ST_INTEG,
        ST_DEINT,
        ST_IZERO
    } seq_state_t;

    localparam logic [1:0] PH_IZERO = 2'b00;
    localparam logic [1:0] PH_AZERO = 2'b01;
    localparam logic [1:0] PH_INTEG = 2'b10;
    localparam logic [1:0] PH_DEINT = 2'b11;

endpackage

// File: rtl/dslope_sync.sv
module dslope_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_in,
    output logic cmp_s,
    output logic cmp_fall
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= cmp_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign cmp_s    = sync_q;
    assign cmp_fall = prev_q & ~sync_q;

endmodule

// File: rtl/dslope_fsm.sv
module dslope_fsm
    import dslope_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] int_len,
    input  logic [CNT_W-1:0] az_len,
    input  logic             cmp_s,
    input  logic             cmp_fall,
    output logic [1:0]       phase,
    output logic             busy,
    output logic             done,
    output logic             sign_take,
    output logic             cap_take,
    output logic             ovr_take,
    output logic [CNT_W:0]   tmr
);
    localparam int TW = CNT_W + 1;

    seq_state_t       state_q, state_nxt;
    logic [TW-1:0]    tmr_q;
    logic [TW-1:0]    az_last, int_last, fs_last;
    logic             done_q;

    always_comb begin
        int_last = {1'b0, int_len} - TW'(1);
        fs_last  = {int_len, 1'b0} - TW'(1);
        az_last  = (az_len == '0) ? int_last : ({1'b0, az_len} - TW'(1));
    end

    // next state and capture strobes
    always_comb begin
        state_nxt = state_q;
        sign_take = 1'b0;
        cap_take  = 1'b0;
        ovr_take  = 1'b0;
        unique case (state_q)
            ST_IDLE:   if (start) state_nxt = ST_AZ_RUN;
            ST_AZ_RUN: if (tmr_q == az_last) state_nxt = ST_INTEG;
            ST_INTEG: begin
                if (tmr_q == int_last) begin
                    state_nxt = ST_DEINT;
                    sign_take = 1'b1;
                end
            end
            ST_DEINT: begin
                if (cmp_fall) begin
                    state_nxt = ST_IZERO;
                    cap_take  = 1'b1;
                end else if (tmr_q == fs_last) begin
                    state_nxt = ST_IZERO;
                    ovr_take  = 1'b1;
                end
            end
            ST_IZERO: if (cmp_s || tmr_q == int_last) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // state register, shared phase timer, end-of-conversion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_nxt;
            done_q  <= (state_q == ST_IZERO) && (state_nxt == ST_IDLE);
            if (state_nxt != state_q || state_q == ST_IDLE)
                tmr_q <= '0;
            else
                tmr_q <= tmr_q + TW'(1);
        end
    end

    // outputs
    always_comb begin
        busy  = 1'b1;
        phase = PH_AZERO;
        unique case (state_q)
            ST_IDLE:   begin phase = PH_AZERO; busy = 1'b0; end
            ST_AZ_RUN: phase = PH_AZERO;
            ST_INTEG:  phase = PH_INTEG;
            ST_DEINT:  phase = PH_DEINT;
            ST_IZERO:  phase = PH_IZERO;
            default:   begin phase = PH_AZERO; busy = 1'b0; end
        endcase
    end

    assign done = done_q;
    assign tmr  = tmr_q;

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE && phase == PH_AZERO));

    assert_phase_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |-> (phase == 2'($past(phase) + 2'd1)));

    assert_deint_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEINT) |-> (tmr_q <= fs_last));

    assert_iz_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IZERO && cmp_s) |=> (state_q == ST_IDLE));

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == PH_AZERO && !busy));

endmodule

// File: rtl/dslope_capture.sv
module dslope_capture #(
    parameter int CNT_W    = 16,
    parameter int LAT_COMP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sign_take,
    input  logic             cap_take,
    input  logic             ovr_take,
    input  logic             cmp_s,
    input  logic [CNT_W:0]   tmr,
    input  logic [CNT_W-1:0] int_len,
    output logic             sign_o,
    output logic [CNT_W:0]   mag_o,
    output logic             ovr_o
);
    localparam int            TW    = CNT_W + 1;
    localparam logic [TW-1:0] LAT_W = TW'(LAT_COMP);

    logic          sign_q, ovr_q;
    logic [TW-1:0] mag_q;
    logic [TW-1:0] comp_cnt;

    always_comb comp_cnt = (tmr >= LAT_W) ? (tmr - LAT_W) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sign_q <= 1'b0;
            ovr_q  <= 1'b0;
            mag_q  <= '0;
        end else begin
            if (sign_take) sign_q <= cmp_s;
            if (cap_take) begin
                mag_q <= comp_cnt;
                ovr_q <= 1'b0;
            end else if (ovr_take) begin
                mag_q <= {int_len, 1'b0};
                ovr_q <= 1'b1;
            end
        end
    end

    assign sign_o = sign_q;
    assign mag_o  = mag_q;
    assign ovr_o  = ovr_q;

    assert_sign_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sign_take |=> $stable(sign_q));

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq #(
    parameter int CNT_W    = 16,
    parameter int LAT_COMP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_in,
    input  logic [CNT_W-1:0] int_len,
    input  logic [CNT_W-1:0] az_len,
    output logic [1:0]       phase_sel,
    output logic             busy,
    output logic             done,
    output logic             result_pos,
    output logic [CNT_W:0]   result_mag,
    output logic             overrange
);
    logic           cmp_s, cmp_fall;
    logic           sign_take, cap_take, ovr_take;
    logic [CNT_W:0] tmr;

    dslope_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_in   (cmp_in),
        .cmp_s    (cmp_s),
        .cmp_fall (cmp_fall)
    );

    dslope_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .int_len   (int_len),
        .az_len    (az_len),
        .cmp_s     (cmp_s),
        .cmp_fall  (cmp_fall),
        .phase     (phase_sel),
        .busy      (busy),
        .done      (done),
        .sign_take (sign_take),
        .cap_take  (cap_take),
        .ovr_take  (ovr_take),
        .tmr       (tmr)
    );

    dslope_capture #(.CNT_W(CNT_W), .LAT_COMP(LAT_COMP)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .sign_take (sign_take),
        .cap_take  (cap_take),
        .ovr_take  (ovr_take),
        .cmp_s     (cmp_s),
        .tmr       (tmr),
        .int_len   (int_len),
        .sign_o    (result_pos),
        .mag_o     (result_mag),
        .ovr_o     (overrange)
    );

endmodule

// File: tb/dslope_seq_test.sv
module dslope_seq_test;
    localparam int CNT_W = 16;
    localparam int LAT   = 2;
    localparam int NEVER = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             cmp_in = 1'b0;
    logic [CNT_W-1:0] int_len = 16'd8;
    logic [CNT_W-1:0] az_len = 16'd0;
    logic [1:0]       phase_sel;
    logic             busy, done, result_pos, overrange;
    logic [CNT_W:0]   result_mag;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dslope_seq #(.CNT_W(CNT_W), .LAT_COMP(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
        .int_len(int_len), .az_len(az_len), .phase_sel(phase_sel),
        .busy(busy), .done(done), .result_pos(result_pos),
        .result_mag(result_mag), .overrange(overrange)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    function automatic bit exp_ovr(input int n, input int dfall);
        return (dfall + 2) > (2 * n - 1);
    endfunction

    function automatic int exp_deint_len(input int n, input int dfall);
        return exp_ovr(n, dfall) ? 2 * n : dfall + 3;
    endfunction

    function automatic int exp_mag(input int n, input int dfall);
        int m;
        if (exp_ovr(n, dfall)) return 2 * n;
        m = dfall + 2 - LAT;
        return (m < 0) ? 0 : m;
    endfunction

    function automatic int exp_iz_len(input int n, input bit ovr, input int zrise);
        if (ovr) return 1;
        return (zrise + 3 < n) ? zrise + 3 : n;
    endfunction

    // one full conversion; dfall >= 3, or NEVER for no falling edge
    task automatic run_conv(input int n, input int az, input bit sgn,
                            input int dfall, input int zrise);
        int cnt;
        bit ovr;
        ovr = exp_ovr(n, dfall);
        int_len = CNT_W'(n);
        az_len  = CNT_W'(az);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (phase_sel == 2'b01 && busy) begin
            cmp_in = 1'($urandom % 2);   // R4: noise during auto-zero is ignored
            cnt++;
            @(negedge clk);
        end
        check(cnt == ((az == 0) ? n : az), "R4", "auto-zero length", cnt, (az == 0) ? n : az);
        check(phase_sel == 2'b10, "R2", "code after auto-zero", phase_sel, 2);
        cnt = 0;
        while (phase_sel == 2'b10) begin
            if (cnt < n - 3) cmp_in = 1'($urandom % 2);
            else             cmp_in = sgn;
            start = (cnt == 1);          // R3: start while busy is ignored
            cnt++;
            @(negedge clk);
        end
        start = 1'b0;
        check(cnt == n, "R5", "integrate length", cnt, n);
        check(phase_sel == 2'b11, "R2", "code after integrate", phase_sel, 3);
        cnt = 0;
        while (phase_sel == 2'b11) begin
            if (cnt == 0) cmp_in = 1'b1;
            if (cnt == dfall) cmp_in = 1'b0;
            cnt++;
            @(negedge clk);
        end
        check(cnt == exp_deint_len(n, dfall), ovr ? "R8" : "R7", "deintegrate length",
              cnt, exp_deint_len(n, dfall));
        check(phase_sel == 2'b00, "R2", "code after deintegrate", phase_sel, 0);
        cnt = 0;
        while (phase_sel == 2'b00) begin
            if (cnt == zrise) cmp_in = 1'b1;
            cnt++;
            @(negedge clk);
        end
        check(cnt == exp_iz_len(n, ovr, zrise), (zrise + 3 >= n) ? "R10" : "R9",
              "integrator-zero length", cnt, exp_iz_len(n, ovr, zrise));
        check(phase_sel == 2'b01 && !busy, "R2", "return to idle code", phase_sel, 1);
        check(done == 1'b1, "R11", "done pulse", done, 1);
        check(result_pos == sgn, "R6", "sign", result_pos, sgn);
        check(int'(result_mag) == exp_mag(n, dfall), ovr ? "R8" : "R7", "magnitude",
              int'(result_mag), exp_mag(n, dfall));
        check(overrange == ovr, "R8", "overrange flag", overrange, ovr);
        @(negedge clk);
        check(done == 1'b0, "R11", "done width", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0D5A));
        repeat (3) @(negedge clk);
        check(phase_sel == 2'b01, "R1", "reset code", phase_sel, 1);
        check(!busy && !done && !overrange, "R1", "reset flags", {busy, done, overrange}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            cmp_in = 1'($urandom % 2);
            @(negedge clk);
            check(phase_sel == 2'b01 && !busy, "R3", "idle hold", phase_sel, 1);
        end
        // directed corners
        run_conv(8, 0, 1'b1, 5, 2);          // R4 default auto-zero length
        run_conv(8, 5, 1'b0, 13, 1);         // R7 largest in-range count (2N-3)
        run_conv(8, 3, 1'b1, NEVER, 0);      // R8 no crossing, positive
        run_conv(6, 4, 1'b0, NEVER, 0);      // R8 no crossing, negative
        run_conv(6, 2, 1'b1, 3, 40);         // R10 integrator-zero timeout
        run_conv(10, 0, 1'b0, 3, 0);         // R9 immediate rise
        // random conversions
        for (int k = 0; k < 40; k++) begin
            int n, az, df, zr;
            bit sg;
            n  = 4 + int'($urandom % 21);
            az = ($urandom % 4 == 0) ? 0 : 1 + int'($urandom % 24);
            sg = 1'($urandom % 2);
            df = ($urandom % 5 == 0) ? NEVER : 3 + int'($urandom % (2 * n - 5));
            zr = int'($urandom % (n + 3));
            run_conv(n, az, sg, df, zr);
        end
        summary();
    end

endmodule